// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block holds a small fully associative set of recent page translations for a 32-bit virtual address space. Every lookup compares the 20-bit virtual page number and the current 6-bit address-space tag against all stored entries in parallel. On a match it returns the physical frame joined with the untouched 12-bit page offset. The address-space tag lets many processes keep translations resident at once, so a context switch needs no flush.

The top three address bits pick a segment before any compare is made. Part of the kernel space bypasses translation and maps straight onto physical addresses, either cached or uncached. The lookup also enforces two protection rules: a user-mode access into kernel space faults, and so does a store to a read-only page. Hardware never walks a page table. A miss is flagged, and software refills a chosen slot through a dedicated write port. Each hit marks its entry as referenced, and each permitted store also marks it as modified.

Top module: `xlat_tlb`

## Requirements
- R1: After a synchronous reset every slot is empty, so every translated lookup reports a miss.
- R2: Address bits [31:29] select the segment: 0xx is user space and translated; 100 is kernel direct space with physical address {3'b000, va[28:0]} and `lk_uncached`=0; 101 is the same mapping with `lk_uncached`=1; 11x is kernel space and translated.
- R3: A translated lookup hits only when a slot is valid, its page number equals va[31:12] and its tag equals `lk_asid`. The physical address is then {frame, va[11:0]} and `lk_mapped`=1.
- R4: A translated lookup that matches no slot raises `lk_miss` with `lk_hit`=0 and `lk_paddr`=0, and it changes no slot.
- R5: Slots that share a page number but carry different tags coexist, and each answers only its own tag.
- R6: A store (`lk_write`=1) that matches a slot whose `rw` bit is 0 raises `lk_fault` instead of a hit and leaves the dirty bit clear.
- R7: In user mode (`lk_kernel`=0) any access with va[31]=1 raises `lk_fault`, whatever the slots hold.
- R8: A translated hit sets the referenced bit of the matching slot from the next cycle on.
- R9: A store hit on a slot with `rw`=1 sets its dirty bit from the next cycle on.
- R10: A write-port strobe replaces the whole slot at `wr_idx` on the next edge. When the same slot is also updated by a hit in that cycle, the written contents win.
- R11: With `lk_valid`=0 the outputs hit, miss, fault, uncached, mapped, dirty, referenced and `lk_paddr` are all 0.
- R12: `lk_dirty` and `lk_ref` show the matching slot's bits as they stood before this lookup's update, whenever a translated lookup matches a slot and raises no user-mode fault. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_asid | input | 6 | Current address-space tag |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_kernel | input | 1 | 1 when the access is in kernel mode |
| wr_en | input | 1 | Load a slot |
| wr_idx | input | 6 | Slot to load |
| wr_vpn | input | 20 | Page number for the loaded slot |
| wr_asid | input | 6 | Tag for the loaded slot |
| wr_pfn | input | 20 | Physical frame for the loaded slot |
| wr_valid | input | 1 | Valid bit for the loaded slot |
| wr_dirty | input | 1 | Initial dirty bit |
| wr_ref | input | 1 | Initial referenced bit |
| wr_rw | input | 1 | 1 = read/write, 0 = read-only |
| lk_hit | output | 1 | Lookup succeeded |
| lk_miss | output | 1 | Translated lookup found no slot |
| lk_fault | output | 1 | Protection violation |
| lk_paddr | output | 32 | Physical address, 0 unless hit |
| lk_uncached | output | 1 | Hit in the uncached direct segment |
| lk_mapped | output | 1 | Hit came from a slot |
| lk_dirty | output | 1 | Matching slot's dirty bit before update |
| lk_ref | output | 1 | Matching slot's referenced bit before update |

## Verification
The assertions take for granted that software never holds two valid slots with the same page number and tag, because the match vector is checked to be one-hot or empty. The stimulus loads every slot with a page number and tag pair that no other valid slot holds. When it overwrites a slot, it replaces that slot's pair rather than copying it elsewhere. The update properties also assume that refills arrive only through the write port, so a slot changes only through a hit or a strobe.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_W   = 12;
    localparam int VPN_W  = VA_W - PG_W;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 6;
    localparam int SEG_W  = 3;
    localparam int DIR_W  = VA_W - SEG_W;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              dirty;
        logic              refd;
        logic              rw;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        SEG_USER      = 2'd0,
        SEG_KDIRECT   = 2'd1,
        SEG_KUNCACHED = 2'd2,
        SEG_KMAPPED   = 2'd3
    } seg_t;

    function automatic seg_t seg_of(input logic [SEG_W-1:0] top);
        if (!top[2])      return SEG_USER;
        else if (top[1])  return SEG_KMAPPED;
        else if (top[0])  return SEG_KUNCACHED;
        else              return SEG_KDIRECT;
    endfunction
endpackage

// File: rtl/xtlb_seg.sv
module xtlb_seg
    import xtlb_pkg::*;
(
    input  logic [SEG_W-1:0] top_bits,
    input  logic             kernel,
    output logic             translated,
    output logic             direct,
    output logic             uncached,
    output logic             priv_fault
);
    seg_t seg;

    always_comb begin
        seg        = seg_of(top_bits);
        translated = (seg == SEG_USER) || (seg == SEG_KMAPPED);
        direct     = (seg == SEG_KDIRECT) || (seg == SEG_KUNCACHED);
        uncached   = (seg == SEG_KUNCACHED);
        priv_fault = !kernel && (seg != SEG_USER);
    end
endmodule

// File: rtl/xtlb_cam.sv
module xtlb_cam
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  tlb_entry_t [ENTRIES-1:0]      ents,
    input  logic [VPN_W-1:0]              vpn,
    input  logic [ASID_W-1:0]             asid,
    output logic                          any,
    output logic [$clog2(ENTRIES)-1:0]    idx,
    output logic [PFN_W-1:0]              sel_pfn,
    output logic                          sel_rw,
    output logic                          sel_dirty,
    output logic                          sel_ref
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] match_vec;
    tlb_entry_t         sel;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ents[g].valid && (ents[g].vpn == vpn) && (ents[g].asid == asid);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) idx = IDX_W'(i);
        end
        any       = |match_vec;
        sel       = ents[idx];
        sel_pfn   = sel.pfn;
        sel_rw    = sel.rw;
        sel_dirty = sel.dirty;
        sel_ref   = sel.refd;
    end

    // R3 / R5: page number and tag together pick at most one slot
    a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    // R3: any valid matching slot has identical key fields
    a_r3_sel_key: assert property (@(posedge clk) disable iff (rst)
        any |-> (sel.valid && sel.vpn == vpn && sel.asid == asid));
endmodule

// File: rtl/xtlb_store.sv
module xtlb_store
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(ENTRIES)-1:0]    wr_idx,
    input  tlb_entry_t                    wr_ent,
    input  logic                          upd_en,
    input  logic                          upd_dirty,
    input  logic [$clog2(ENTRIES)-1:0]    upd_idx,
    output tlb_entry_t [ENTRIES-1:0]      ents
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else begin
            if (upd_en) begin
                ents[upd_idx].refd <= 1'b1;
                if (upd_dirty) ents[upd_idx].dirty <= 1'b1;
            end
            if (wr_en) ents[wr_idx] <= wr_ent;
        end
    end

    // R10: a strobe leaves exactly the written slot contents
    a_r10_slot_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ents[$past(wr_idx)] == $past(wr_ent));

    // R8: a hit not overridden by a load marks the slot referenced
    a_r8_ref_set: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !(wr_en && wr_idx == upd_idx)) |=> ents[$past(upd_idx)].refd);

    // R9: a permitted store hit marks the slot dirty
    a_r9_dirty_set: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_dirty && !(wr_en && wr_idx == upd_idx)) |=> ents[$past(upd_idx)].dirty);
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [5:0]        lk_asid,
    input  logic              lk_write,
    input  logic              lk_kernel,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [19:0]       wr_vpn,
    input  logic [5:0]        wr_asid,
    input  logic [19:0]       wr_pfn,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_ref,
    input  logic              wr_rw,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [31:0]       lk_paddr,
    output logic              lk_uncached,
    output logic              lk_mapped,
    output logic              lk_dirty,
    output logic              lk_ref
);
    tlb_entry_t [ENTRIES-1:0] ents;
    tlb_entry_t               wr_ent;
    logic                     s_trans, s_direct, s_unc, s_priv;
    logic                     any;
    logic [IDX_W-1:0]         idx;
    logic [PFN_W-1:0]         sel_pfn;
    logic                     sel_rw, sel_dirty, sel_ref;
    logic                     trans, matched, ro_fault, upd_en;

    assign wr_ent = '{valid: wr_valid, vpn: wr_vpn, asid: wr_asid, pfn: wr_pfn,
                      dirty: wr_dirty, refd: wr_ref, rw: wr_rw};

    xtlb_seg u_seg (
        .top_bits   (lk_vaddr[VA_W-1 -: SEG_W]),
        .kernel     (lk_kernel),
        .translated (s_trans),
        .direct     (s_direct),
        .uncached   (s_unc),
        .priv_fault (s_priv)
    );

    xtlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .ents      (ents),
        .vpn       (lk_vaddr[VA_W-1:PG_W]),
        .asid      (lk_asid),
        .any       (any),
        .idx       (idx),
        .sel_pfn   (sel_pfn),
        .sel_rw    (sel_rw),
        .sel_dirty (sel_dirty),
        .sel_ref   (sel_ref)
    );

    xtlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_ent    (wr_ent),
        .upd_en    (upd_en),
        .upd_dirty (lk_write),
        .upd_idx   (idx),
        .ents      (ents)
    );

    always_comb begin
        trans       = lk_valid && s_trans;
        matched     = trans && any && !s_priv;
        ro_fault    = matched && lk_write && !sel_rw;
        lk_fault    = lk_valid && (s_priv || ro_fault);
        lk_miss     = trans && !any && !s_priv;
        lk_mapped   = matched && !ro_fault;
        lk_hit      = lk_mapped || (lk_valid && s_direct && !s_priv);
        lk_uncached = lk_hit && s_unc;
        lk_dirty    = matched && sel_dirty;
        lk_ref      = matched && sel_ref;
        upd_en      = lk_mapped;
        if (!lk_hit)        lk_paddr = '0;
        else if (lk_mapped) lk_paddr = {sel_pfn, lk_vaddr[PG_W-1:0]};
        else                lk_paddr = {{SEG_W{1'b0}}, lk_vaddr[DIR_W-1:0]};
    end

    // R3: the page offset crosses translation unchanged
    a_r3_offset_pass: assert property (@(posedge clk) disable iff (rst)
        lk_mapped |-> lk_paddr[PG_W-1:0] == lk_vaddr[PG_W-1:0]);

    // R11: no outcome without a request
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_dirty || lk_ref));

    // R6: hit, miss and fault are mutually exclusive
    a_r6_outcome_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    // R2: uncached only on direct-segment hits
    a_r2_uncached_direct: assert property (@(posedge clk) disable iff (rst)
        lk_uncached |-> (lk_hit && !lk_mapped && lk_vaddr[31:29] == 3'b101));

    // R7: user mode never reaches kernel space
    a_r7_user_kernel: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_kernel && lk_vaddr[31]) |-> (lk_fault && !lk_hit));
endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
    localparam int N = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_write = 0, lk_kernel = 0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        wr_en = 0, wr_valid = 0, wr_dirty = 0, wr_ref = 0, wr_rw = 0;
    logic [5:0]  wr_idx = '0, wr_asid = '0;
    logic [19:0] wr_vpn = '0, wr_pfn = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_uncached, lk_mapped, lk_dirty, lk_ref;
    logic [31:0] lk_paddr;

    xlat_tlb u_xlat_tlb (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_write(lk_write), .lk_kernel(lk_kernel),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_pfn(wr_pfn), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .wr_ref(wr_ref), .wr_rw(wr_rw), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_fault(lk_fault), .lk_paddr(lk_paddr), .lk_uncached(lk_uncached),
        .lk_mapped(lk_mapped), .lk_dirty(lk_dirty), .lk_ref(lk_ref)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_v[N], m_d[N], m_r[N], m_rw[N];
    logic [19:0] m_vpn[N], m_pfn[N];
    logic [5:0]  m_asid[N];

    task automatic step(input string tag);
        int mi;
        bit trans, direct, priv, ro, e_hit, e_miss, e_fault, e_unc, e_map, e_d, e_r;
        logic [31:0] e_pa;
        logic [38:0] got, exp;
        @(negedge clk);
        mi = -1;
        for (int i = 0; i < N; i++)
            if (mi < 0 && m_v[i] && m_vpn[i] == lk_vaddr[31:12] && m_asid[i] == lk_asid) mi = i;
        trans   = lk_valid && (!lk_vaddr[31] || lk_vaddr[31:30] == 2'b11);
        direct  = lk_valid && lk_vaddr[31:30] == 2'b10;
        priv    = lk_valid && !lk_kernel && lk_vaddr[31];
        ro      = trans && !priv && mi >= 0 && lk_write && !m_rw[mi];
        e_fault = priv || ro;
        e_hit   = !e_fault && (direct || (trans && mi >= 0));
        e_miss  = !e_fault && trans && mi < 0;
        e_map   = e_hit && trans;
        e_unc   = e_hit && direct && lk_vaddr[29];
        e_pa    = '0;
        if (e_map)      e_pa = {m_pfn[mi], lk_vaddr[11:0]};
        else if (e_hit) e_pa = {3'b000, lk_vaddr[28:0]};
        e_d = (trans && !priv && mi >= 0) ? m_d[mi] : 1'b0;
        e_r = (trans && !priv && mi >= 0) ? m_r[mi] : 1'b0;
        got = {lk_hit, lk_miss, lk_fault, lk_uncached, lk_mapped, lk_dirty, lk_ref, lk_paddr};
        exp = {e_hit, e_miss, e_fault, e_unc, e_map, e_d, e_r, e_pa};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s va=%h got h/m/f/u/map/d/r=%b pa=%h exp %b pa=%h",
                     tag, lk_vaddr, got[38:32], got[31:0], exp[38:32], exp[31:0]);
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; end
        end else begin
            if (e_map) begin m_r[mi] = 1; if (lk_write) m_d[mi] = 1; end
            if (wr_en) begin
                m_v[wr_idx] = wr_valid; m_vpn[wr_idx] = wr_vpn; m_asid[wr_idx] = wr_asid;
                m_pfn[wr_idx] = wr_pfn; m_d[wr_idx] = wr_dirty; m_r[wr_idx] = wr_ref;
                m_rw[wr_idx] = wr_rw;
            end
        end
        #1;
    endtask

    task automatic load(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                        input logic [19:0] pfn, input bit rw, input bit v);
        wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_rw = rw; wr_valid = v; wr_dirty = 0; wr_ref = 0;
        step("R10");
        wr_en = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [5:0] asid, input bit wr,
                        input bit k, input string tag);
        lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_write = wr; lk_kernel = k;
        step(tag);
        lk_valid = 0; lk_write = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_rw[i] = 0; end
        repeat (2) @(posedge clk);
        #1 rst = 0;

        look(32'h0040_1234, 6'd0, 0, 1, "R1");       // empty after reset
        look(32'hC000_0010, 6'd0, 0, 1, "R1");
        step("R11");                                 // idle request
        look(32'h8123_4567, 6'd0, 0, 1, "R2");       // direct cached
        look(32'hA000_0ABC, 6'd0, 1, 1, "R2");       // direct uncached

        load(0,  20'h00401, 6'd3, 20'h12345, 1, 1);
        load(63, 20'h00401, 6'd5, 20'h54321, 0, 1);
        load(10, 20'hC0002, 6'd3, 20'h0ABCD, 1, 1);
        load(11, 20'h00777, 6'd3, 20'h0FFFF, 1, 0);  // invalid slot

        look(32'h0040_1ABC, 6'd3, 0, 0, "R3");       // first hit, ref shows 0 (R12)
        look(32'h0040_1ABC, 6'd3, 0, 0, "R8");       // ref now 1
        look(32'h0040_1ABC, 6'd5, 0, 0, "R5");       // other tag, other frame
        look(32'h0040_1ABC, 6'd7, 0, 0, "R4");       // no tag match
        look(32'h0077_7000, 6'd3, 0, 0, "R3");       // invalid slot misses
        look(32'h0040_1004, 6'd5, 1, 0, "R6");       // store to read-only
        look(32'h0040_1004, 6'd5, 0, 0, "R6");       // dirty still clear
        look(32'h0040_1008, 6'd3, 1, 0, "R9");       // permitted store
        look(32'h0040_1008, 6'd3, 0, 0, "R9");       // dirty now set
        look(32'hC000_2010, 6'd3, 0, 0, "R7");       // user into kernel mapped
        look(32'h8000_0000, 6'd3, 0, 0, "R7");       // user into kernel direct
        look(32'hC000_2010, 6'd3, 0, 1, "R2");       // kernel mapped hit
        look(32'hC000_2010, 6'd3, 1, 1, "R12");      // shows ref set, then dirty

        load(0, 20'h00402, 6'd3, 20'h00AAA, 1, 1);   // overwrite slot 0
        look(32'h0040_1000, 6'd3, 0, 0, "R10");
        look(32'h0040_2FFF, 6'd3, 0, 0, "R10");

        // hit on slot 63 and load of slot 63 in the same cycle: load wins
        wr_en = 1; wr_idx = 6'd63; wr_vpn = 20'h00900; wr_asid = 6'd5; wr_pfn = 20'h00001;
        wr_rw = 1; wr_valid = 1; wr_dirty = 0; wr_ref = 0;
        lk_valid = 1; lk_vaddr = 32'h0040_1000; lk_asid = 6'd5; lk_write = 0; lk_kernel = 0;
        step("R10");
        wr_en = 0; lk_valid = 0;
        look(32'h0090_0123, 6'd5, 0, 0, "R10");
        look(32'h0040_1000, 6'd5, 0, 0, "R4");

        for (int i = 20; i < 30; i++)
            load(i, 20'h10000 + 20'(i), 6'(i), 20'h20000 + 20'(i * 3), i[0], 1);
        for (int i = 20; i < 30; i++)
            look({20'h10000 + 20'(i), 12'h5A5}, 6'(i), 1, 1, "R3");
        for (int i = 20; i < 30; i++)
            look({20'h10000 + 20'(i), 12'h001}, 6'(i), 0, 1, "R9");

        rst = 1;
        step("R1");
        rst = 0;
        look(32'h1001_4000, 6'd20, 0, 1, "R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule